// File: doc/BRIEF.md
# Deferred Write-Buffer Retire Controller

This block is the column-command logic of a memory device that completes each write in two steps. Every clock cycle is one packet slot, in which the block takes a column packet made of a framing bit, a command, a device ID, a bank and a column. A write addressed to this device loads its address into a one-entry write buffer. The write data arrives a fixed number of slots later and is captured into the same buffer. The buffer is committed to a small sense-amp storage array later, with a per-byte mask applied.

The commit, called the retire, is not a plain delayed write. It is first allowed a fixed number of slots after the write command. It then fires on the first framed slot that does not carry a read to this device. A run of same-device reads can therefore hold the buffer back for as long as it lasts, and those reads still return the old stored contents. Reads return storage data a fixed number of slots after the command, together with a valid strobe. The delays, the device ID and the bank, column and byte counts are module parameters.

Top module: `colwrite_retire`

## Requirements
- R1: A framed write (command code 2'b10) whose device field equals DEV_ID opens a buffer entry. Its data is taken from wrData in the slot T_CWD slots after the command. Writes to other devices, unframed packets and data outside that slot have no effect on storage.
- R2: A buffered write retires at the earliest in the slot T_RTR slots after its command, provided that slot is framed and is not a read to this device.
- R3: A slot with colFrame low never retires the buffer, and its command is ignored.
- R4: A framed read (command code 2'b01) to this device, to any bank or column, blocks the retire in its slot. Any number of such reads in a row keep it blocked.
- R5: A framed read to another device, a write to any device, or a no-op (2'b00, with 2'b11 treated the same) lets a due retire happen in that slot.
- R6: The byte mask is taken from wrMask in the slot where the retire happens. Bit i high keeps byte i (bits 8i+7..8i) of the stored word unchanged, and bit i low writes the buffered byte.
- R7: A read to the buffered bank and column returns the old stored word while the entry is pending. From the slot after the retire onward it returns the merged new word.
- R8: If the data of a new write arrives while the buffer still holds an unretired entry, that entry retires in the same slot, whatever packet that slot holds. No write data is lost.
- R9: After reset, rdValid is low and every stored word is zero. A framed read to this device in slot k drives rdValid high and rdData with the addressed word T_CAC slots later. rdValid is low in every other slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, one packet per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| colFrame | input | 1 | A column packet is present in this slot |
| colCmd | input | 2 | 00 no-op, 01 read, 10 write, 11 no-op |
| colDev | input | DEV_W | Target device ID |
| colBank | input | BANK_W | Target bank |
| colCol | input | COL_W | Target column |
| wrData | input | 8*BYTES | Write data bus, sampled T_CWD slots after a write |
| wrMask | input | BYTES | Byte mask for the retiring slot, 1 keeps the old byte |
| rdValid | output | 1 | Read data valid |
| rdData | output | 8*BYTES | Read data |

## Verification
Read data is due T_CAC slots after the read command. The output registers load on the edge that ends slot k+T_CAC-1, so the bench files each expected read result T_CAC-1 slot indices ahead and compares rdValid and rdData 1 ns after every rising edge. Write data is presented exactly T_CWD slots after its command, and the retire is only visible through later reads. For that reason the stimulus places same-address reads just before, in the middle of and just after the slot where the retire is due or forced, so that a retire one slot early or late changes a compared word.

// File: rtl/colret_pkg.sv
package colret_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_RSV = 2'b11
  } colCmd_e;

  typedef struct packed {
    logic loadBuf;   // pending write data captured this slot
    logic retire;    // buffer committed to storage this slot
    logic readEn;    // read to this device this slot
  } dpStrobe_t;
endpackage

// File: rtl/colret_ctrl.sv
module colret_ctrl
  import colret_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int DEV_ID = 3,
  parameter int BANK_W = 2,
  parameter int COL_W  = 3,
  parameter int T_CWD  = 2,
  parameter int T_RTR  = 4,
  parameter int T_CAC  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              colFrame,
  input  logic [1:0]        colCmd,
  input  logic [DEV_W-1:0]  colDev,
  input  logic [BANK_W-1:0] colBank,
  input  logic [COL_W-1:0]  colCol,
  output dpStrobe_t         strobe,
  output logic [BANK_W-1:0] retBank,
  output logic [COL_W-1:0]  retCol,
  output logic              rdValid
);
  localparam int CNT_W    = $clog2(T_RTR + 1);
  localparam int DUE_INIT = T_RTR - T_CWD - 1;

  logic myDev, isMyRead, isMyWr, headV, retireNow;
  logic [T_CWD-1:0]  pipeV;
  logic [BANK_W-1:0] pipeB [T_CWD];
  logic [COL_W-1:0]  pipeC [T_CWD];
  logic              pendV;
  logic [BANK_W-1:0] pendB;
  logic [COL_W-1:0]  pendC;
  logic [CNT_W-1:0]  dueCnt;
  logic [T_CAC-1:0]  rdPipeV;

  assign myDev    = (colDev == DEV_W'(DEV_ID));
  assign isMyRead = colFrame && myDev && (colCmd_e'(colCmd) == CMD_RD);
  assign isMyWr   = colFrame && myDev && (colCmd_e'(colCmd) == CMD_WR);
  assign headV    = pipeV[T_CWD-1];

  // Forced retire when new data lands on a full buffer; otherwise first free framed slot once due.
  assign retireNow = pendV && (headV || ((dueCnt == '0) && colFrame && !isMyRead));

  // Address delay line from write command to data arrival.
  generate
    for (genvar s = 0; s < T_CWD; s++) begin : g_wrPipe
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pipeV[s] <= 1'b0;
          pipeB[s] <= '0;
          pipeC[s] <= '0;
        end else if (s == 0) begin
          pipeV[s] <= isMyWr;
          pipeB[s] <= colBank;
          pipeC[s] <= colCol;
        end else begin
          pipeV[s] <= pipeV[(s == 0) ? 0 : s-1];
          pipeB[s] <= pipeB[(s == 0) ? 0 : s-1];
          pipeC[s] <= pipeC[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendV  <= 1'b0;
      pendB  <= '0;
      pendC  <= '0;
      dueCnt <= '0;
    end else if (headV) begin
      pendV  <= 1'b1;
      pendB  <= pipeB[T_CWD-1];
      pendC  <= pipeC[T_CWD-1];
      dueCnt <= CNT_W'(DUE_INIT);
    end else begin
      if (retireNow) pendV <= 1'b0;
      if (dueCnt != '0) dueCnt <= dueCnt - 1'b1;
    end
  end

  // Read valid delay line.
  generate
    for (genvar s = 0; s < T_CAC; s++) begin : g_rdPipe
      always_ff @(posedge clk) begin
        if (!rstN)       rdPipeV[s] <= 1'b0;
        else if (s == 0) rdPipeV[s] <= isMyRead;
        else             rdPipeV[s] <= rdPipeV[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign strobe.loadBuf = headV;
  assign strobe.retire  = retireNow;
  assign strobe.readEn  = isMyRead;
  assign retBank = pendB;
  assign retCol  = pendC;
  assign rdValid = rdPipeV[T_CAC-1];

  initial begin
    assert (T_RTR > T_CWD && T_CWD >= 1 && T_CAC >= 1)
      else $error("colret_ctrl: need T_RTR > T_CWD >= 1 and T_CAC >= 1");
  end

  assert_unframed_skip_R3: assert property (@(posedge clk) disable iff (!rstN)
    pendV && !headV && !colFrame |=> pendV);
  assert_hold_on_own_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    pendV && !headV && isMyRead |=> pendV);
  assert_retire_free_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    pendV && !headV && (dueCnt == '0) && colFrame && !isMyRead |=> !pendV);
  assert_no_loss_R8: assert property (@(posedge clk) disable iff (!rstN)
    headV |=> pendV);
endmodule

// File: rtl/colret_datapath.sv
module colret_datapath
  import colret_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 3,
  parameter int BYTES  = 4,
  parameter int T_CAC  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [BANK_W-1:0]  retBank,
  input  logic [COL_W-1:0]   retCol,
  input  logic [BANK_W-1:0]  rdBank,
  input  logic [COL_W-1:0]   rdCol,
  input  logic [8*BYTES-1:0] wrData,
  input  logic [BYTES-1:0]   wrMask,
  output logic [8*BYTES-1:0] rdData
);
  localparam int WORD_W = 8 * BYTES;
  localparam int ADDR_W = BANK_W + COL_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] bufData, mergeWord;
  logic [WORD_W-1:0] rdPipe [T_CAC];
  logic [ADDR_W-1:0] retIdx, rdIdx;

  assign retIdx = {retBank, retCol};
  assign rdIdx  = {rdBank, rdCol};

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_merge
      assign mergeWord[8*b +: 8] = wrMask[b] ? mem[retIdx][8*b +: 8] : bufData[8*b +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strobe.retire)  mem[retIdx] <= mergeWord;
      if (strobe.loadBuf) bufData <= wrData;
    end
  end

  generate
    for (genvar s = 0; s < T_CAC; s++) begin : g_rdData
      always_ff @(posedge clk) begin
        if (!rstN)       rdPipe[s] <= '0;
        else if (s == 0) rdPipe[s] <= mem[rdIdx];
        else             rdPipe[s] <= rdPipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign rdData = rdPipe[T_CAC-1];

  assert_mask_keeps_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retire && (&wrMask) |=> mem[$past(retIdx)] == $past(mem[retIdx]));
  assert_mask_open_writes_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retire && (wrMask == '0) |=> mem[$past(retIdx)] == $past(bufData));
  assert_read_before_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.readEn |=> rdPipe[0] == $past(mem[rdIdx]));
endmodule

// File: rtl/colwrite_retire.sv
module colwrite_retire
  import colret_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int DEV_ID = 3,
  parameter int BANKS  = 4,
  parameter int COLS   = 8,
  parameter int BYTES  = 4,
  parameter int T_CWD  = 2,
  parameter int T_RTR  = 4,
  parameter int T_CAC  = 3,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               colFrame,
  input  logic [1:0]         colCmd,
  input  logic [DEV_W-1:0]   colDev,
  input  logic [BANK_W-1:0]  colBank,
  input  logic [COL_W-1:0]   colCol,
  input  logic [8*BYTES-1:0] wrData,
  input  logic [BYTES-1:0]   wrMask,
  output logic               rdValid,
  output logic [8*BYTES-1:0] rdData
);
  dpStrobe_t         strobe;
  logic [BANK_W-1:0] retBank;
  logic [COL_W-1:0]  retCol;

  colret_ctrl #(
    .DEV_W(DEV_W), .DEV_ID(DEV_ID), .BANK_W(BANK_W), .COL_W(COL_W),
    .T_CWD(T_CWD), .T_RTR(T_RTR), .T_CAC(T_CAC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .colFrame(colFrame), .colCmd(colCmd),
    .colDev(colDev), .colBank(colBank), .colCol(colCol),
    .strobe(strobe), .retBank(retBank), .retCol(retCol), .rdValid(rdValid)
  );

  colret_datapath #(
    .BANK_W(BANK_W), .COL_W(COL_W), .BYTES(BYTES), .T_CAC(T_CAC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .retBank(retBank), .retCol(retCol),
    .rdBank(colBank), .rdCol(colCol), .wrData(wrData), .wrMask(wrMask),
    .rdData(rdData)
  );
endmodule

// File: tb/tb_colwrite_retire.sv
`timescale 1ns/1ps
module tb_colwrite_retire;
  localparam int ID = 3, T_CWD = 2, T_RTR = 4, T_CAC = 3;
  localparam int NV = 26;
  // {frame, cmd, dev, bank, col, data, mask, reqTag}
  localparam logic [52:0] VEC [NV] = '{
    {1'b1,2'd2,5'd3,2'd1,3'd2,32'h0,4'h0,4'd1},        // R1 write b1c2
    {1'b1,2'd0,5'd3,2'd0,3'd0,32'h0,4'h0,4'd9},
    {1'b0,2'd0,5'd0,2'd0,3'd0,32'h11223344,4'h0,4'd1}, // R1 data slot
    {1'b1,2'd1,5'd3,2'd1,3'd2,32'h0,4'h0,4'd7},        // R7 old
    {1'b1,2'd1,5'd3,2'd0,3'd0,32'h0,4'h0,4'd4},        // R4 due, blocked
    {1'b1,2'd1,5'd3,2'd3,3'd7,32'h0,4'h0,4'd4},        // R4
    {1'b1,2'd1,5'd3,2'd1,3'd2,32'h0,4'h0,4'd7},        // R7 still old
    {1'b0,2'd0,5'd0,2'd0,3'd0,32'h0,4'h0,4'd3},        // R3 unframed
    {1'b1,2'd1,5'd5,2'd1,3'd2,32'h0,4'h2,4'd5},        // R5 other dev read retires, R6 byte1 kept
    {1'b1,2'd1,5'd3,2'd1,3'd2,32'h0,4'h0,4'd7},        // R7 new 11220044
    {1'b1,2'd2,5'd3,2'd2,3'd1,32'h0,4'h0,4'd8},        // R8 write A
    {1'b1,2'd2,5'd3,2'd2,3'd2,32'h0,4'h0,4'd8},        // R8 write B
    {1'b0,2'd0,5'd0,2'd0,3'd0,32'hAAAAAAAA,4'h0,4'd1},
    {1'b1,2'd1,5'd3,2'd1,3'd1,32'hBBBBBBBB,4'h0,4'd8}, // R8 forced retire of A
    {1'b1,2'd1,5'd3,2'd2,3'd1,32'h0,4'h0,4'd8},        // R8 reads A
    {1'b1,2'd0,5'd3,2'd0,3'd0,32'h0,4'h8,4'd6},        // R6 retire B, byte3 kept
    {1'b1,2'd1,5'd3,2'd2,3'd2,32'h0,4'h0,4'd6},        // R6 expect 00BBBBBB
    {1'b1,2'd2,5'd7,2'd0,3'd0,32'h0,4'h0,4'd1},        // R1 other-dev write
    {1'b1,2'd2,5'd3,2'd0,3'd1,32'h0,4'h0,4'd2},        // R2 write
    {1'b0,2'd0,5'd0,2'd0,3'd0,32'h55555555,4'h0,4'd1}, // R1 ignored data
    {1'b0,2'd0,5'd0,2'd0,3'd0,32'h12345678,4'h0,4'd2},
    {1'b0,2'd0,5'd0,2'd0,3'd0,32'h0,4'h0,4'd2},
    {1'b1,2'd2,5'd9,2'd0,3'd1,32'h0,4'h0,4'd5},        // R5 write to other dev retires, R2 exact slot
    {1'b1,2'd1,5'd3,2'd0,3'd1,32'h0,4'h0,4'd2},        // R2 new
    {1'b0,2'd0,5'd0,2'd0,3'd0,32'hDEADBEEF,4'h0,4'd1},
    {1'b1,2'd1,5'd3,2'd0,3'd0,32'h0,4'h0,4'd1}         // R1 still zero
  };

  logic clk = 0, rstN = 0, colFrame = 0;
  logic [1:0] colCmd = 0;
  logic [4:0] colDev = 0;
  logic [1:0] colBank = 0;
  logic [2:0] colCol = 0;
  logic [31:0] wrData = 0;
  logic [3:0] wrMask = 0;
  logic rdValid;
  logic [31:0] rdData;
  int checks = 0, failures = 0, slotNum = 0;

  // reference model
  logic [31:0] refMem [32];
  logic pV = 0; logic [4:0] pAddr = 0; logic [31:0] pData = 0; int pCnt = 0;
  logic qV [T_CWD]; logic [4:0] qA [T_CWD];
  logic expV [16]; logic [31:0] expD [16]; int expT [16];

  colwrite_retire #(.DEV_W(5), .DEV_ID(ID), .BANKS(4), .COLS(8), .BYTES(4),
    .T_CWD(T_CWD), .T_RTR(T_RTR), .T_CAC(T_CAC)) dut (
    .clk(clk), .rstN(rstN), .colFrame(colFrame), .colCmd(colCmd), .colDev(colDev),
    .colBank(colBank), .colCol(colCol), .wrData(wrData), .wrMask(wrMask),
    .rdValid(rdValid), .rdData(rdData));

  always #5 clk = ~clk;

  task automatic doSlot(input logic [52:0] v);
    logic fr, myRd, myWr, ret; logic [1:0] cm; logic [4:0] ad;
    logic [31:0] dat; logic [3:0] mk; int tg, idx;
    fr = v[52]; cm = v[51:50]; ad = {v[44:43], v[42:40]};
    dat = v[39:8]; mk = v[7:4]; tg = int'(v[3:0]);
    myRd = fr && v[49:45] == 5'(ID) && cm == 2'd1;
    myWr = fr && v[49:45] == 5'(ID) && cm == 2'd2;
    @(negedge clk);
    colFrame = fr; colCmd = cm; colDev = v[49:45]; colBank = v[44:43];
    colCol = v[42:40]; wrData = dat; wrMask = mk;
    if (myRd) begin
      idx = (slotNum + T_CAC - 1) % 16;
      expV[idx] = 1; expD[idx] = refMem[ad]; expT[idx] = tg;
    end
    ret = pV && (qV[T_CWD-1] || (pCnt == 0 && fr && !myRd));
    if (ret) for (int b = 0; b < 4; b++)
      if (!mk[b]) refMem[pAddr][8*b +: 8] = pData[8*b +: 8];
    if (qV[T_CWD-1]) begin
      pV = 1; pAddr = qA[T_CWD-1]; pData = dat; pCnt = T_RTR - T_CWD - 1;
    end else begin
      if (ret) pV = 0;
      if (pCnt > 0) pCnt--;
    end
    for (int s = T_CWD-1; s > 0; s--) begin qV[s] = qV[s-1]; qA[s] = qA[s-1]; end
    qV[0] = myWr; qA[0] = ad;
    @(posedge clk); #1;
    idx = slotNum % 16;
    checks++;
    if (expV[idx]) begin
      if (rdValid !== 1'b1 || rdData !== expD[idx]) begin
        failures++;
        $display("FAIL R%0d slot %0d: rdValid=%b rdData=%h expected 1/%h",
                 expT[idx], slotNum, rdValid, rdData, expD[idx]);
      end
    end else if (rdValid !== 1'b0) begin
      failures++;
      $display("FAIL R9 slot %0d: rdValid=%b expected 0", slotNum, rdValid);
    end
    expV[idx] = 0;
    slotNum++;
  endtask

  function automatic logic [52:0] mk(input logic f, input logic [1:0] c, input logic [4:0] d,
      input logic [1:0] b, input logic [2:0] cl, input logic [31:0] dt, input logic [3:0] m,
      input logic [3:0] t);
    return {f, c, d, b, cl, dt, m, t};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: finished=0 expected 1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) refMem[i] = 0;
    for (int i = 0; i < 16; i++) begin expV[i] = 0; expD[i] = 0; expT[i] = 9; end
    for (int s = 0; s < T_CWD; s++) begin qV[s] = 0; qA[s] = 0; end
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rdValid !== 1'b0) begin
      failures++; $display("FAIL R9 in reset: rdValid=%b expected 0", rdValid);
    end
    @(negedge clk); rstN = 1;
    // R9: stored words read as zero after reset
    doSlot(mk(1, 2'd1, 5'd3, 2'd3, 3'd7, 0, 0, 4'd9));
    for (int i = 0; i < NV; i++) doSlot(VEC[i]);
    // R4: long run of same-device reads holds the retire; R7 old data until it fires
    doSlot(mk(1, 2'd2, 5'd3, 2'd3, 3'd5, 0, 0, 4'd4));
    doSlot(mk(1, 2'd0, 5'd3, 2'd0, 3'd0, 0, 0, 4'd4));
    doSlot(mk(1, 2'd1, 5'd3, 2'd3, 3'd5, 32'hCAFEF00D, 0, 4'd4));
    for (int i = 0; i < 40; i++)
      doSlot(mk(1, 2'd1, 5'd3, 2'(i), 3'd5, 0, 4'hF, 4'd4));
    doSlot(mk(1, 2'd3, 5'd3, 2'd0, 3'd0, 0, 4'h0, 4'd5)); // R5 reserved code acts as no-op
    doSlot(mk(1, 2'd1, 5'd3, 2'd3, 3'd5, 0, 0, 4'd7));    // R7 new word
    for (int i = 0; i < T_CAC + 2; i++) doSlot(mk(1, 2'd0, 5'd3, 0, 0, 0, 0, 4'd9));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule